// File: doc/BRIEF.md
# Vector Control Register Write Unit

This block carries out one instruction: copying a general-purpose register value into a small bank of vector-unit control registers. The instruction word, the value already read from the source register, the program counter of the instruction and three enable inputs are presented together with a one-cycle valid strobe. The block then decodes the word and picks the destination. It applies the access rules and updates at most one register. It also raises at most one exception pulse.

The bank holds a control/status register and four partition-management registers: save, modify, map and unmap. The partition registers exist only when a capability input is high. They also need coprocessor 0 to be enabled. A write to the status register lands first. It then raises a floating-point exception if any pending cause bit meets its enable bit. The address of the faulting instruction is captured for the handler. All register contents are driven out so that the surrounding logic can read them.

Top module: `vcr_write_unit`

## Requirements
- R1: A synchronous active-high reset clears every control register, every exception output and the captured PC to zero.
- R2: A word is this instruction when bits 31:26 are 011110, bits 25:16 are 0000111110 and bits 5:0 are 011001. The destination index is bits 10:6. The source index is bits 15:11 and is shown on `src_idx`. A word whose bits 31:26 are not 011110 has no effect at all.
- R3: A word with bits 31:26 equal to 011110 but either of the other two fields wrong raises `exc_ri` and writes nothing.
- R4: A valid instruction with `vec_en` low raises `exc_vdis` and writes nothing.
- R5: Destination index 1 loads the full 32-bit source value into the status register. The new value is visible one cycle after the strobe.
- R6: After a status write, `exc_fpe` is raised when the cause field (status bits 17:12) ANDed with {1, enable field bits 11:7} is nonzero. Bit 17 is therefore always enabled. The register keeps the new value, and `exc_pc` holds that instruction's PC.
- R7: With `part_cap` and `cp0_en` both high, indices 3, 4, 6 and 7 load the save, modify, map and unmap registers.
- R8: With `part_cap` high and `cp0_en` low, indices 3, 4, 6 and 7 raise `exc_cpu` (unit 0) and write nothing.
- R9: Any other index, and indices 3, 4, 6 and 7 with `part_cap` low, change nothing and raise no exception.
- R10: At most one exception output is high at a time. Priority from highest to lowest is reserved instruction, vector disabled, coprocessor unusable, floating point. Each exception is a one-cycle pulse in the cycle after the strobe. `exc_pc` captures the strobe's PC whenever any exception is raised.
- R11: With `instr_valid` low, nothing changes and no exception is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | One-cycle strobe for the presented instruction |
| instr_word | input | 32 | Instruction word |
| src_value | input | 32 | Value of the source general-purpose register |
| instr_pc | input | 32 | Address of the instruction |
| cp0_en | input | 1 | Coprocessor 0 enabled |
| vec_en | input | 1 | Vector unit enabled |
| part_cap | input | 1 | Partition registers implemented |
| src_idx | output | 5 | Source register index decoded from the word |
| csr_q | output | 32 | Control/status register |
| save_q | output | 32 | Partition save register |
| modify_q | output | 32 | Partition modify register |
| map_q | output | 32 | Partition map register |
| unmap_q | output | 32 | Partition unmap register |
| exc_ri | output | 1 | Reserved-instruction exception pulse |
| exc_vdis | output | 1 | Vector-disabled exception pulse |
| exc_cpu | output | 1 | Coprocessor-0-unusable exception pulse |
| exc_fpe | output | 1 | Floating-point exception pulse |
| exc_pc | output | 32 | PC of the last excepting instruction |

## Verification
Status writes are tried with four values:
- enables set but no cause;
- only the top cause bit set, with no enable;
- a cause bit that meets its own enable;
- a cause bit whose neighbouring enable is set but whose own enable is clear.

Together these separate a correct mask from one that drops the forced top bit or is shifted by one place. Partition indices are driven under every combination of capability and coprocessor enable. Reserved indices 2 and 5 are driven as well, which shows whether the slot lookup hits only the four real registers. Corrupted major, function and minor fields are compared with each other. A disabled unit paired with a raising status value shows that the priority order holds.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 5;

  localparam int MAJ_LO = 26;
  localparam int MAJ_W  = 6;
  localparam int FN_LO  = 16;
  localparam int FN_W   = 10;
  localparam int RS_LO  = 11;
  localparam int CD_LO  = 6;
  localparam int MIN_LO = 0;
  localparam int MIN_W  = 6;

  localparam logic [MAJ_W-1:0] MAJ_CODE = 6'b011110;
  localparam logic [FN_W-1:0]  FN_CODE  = 10'b0000111110;
  localparam logic [MIN_W-1:0] MIN_CODE = 6'b011001;

  localparam logic [IDX_W-1:0] CSR_IDX = 5'd1;

  localparam int PART_N = 4;
  localparam int SLOT_W = $clog2(PART_N);

  localparam int CAUSE_HI = 17;
  localparam int CAUSE_LO = 12;
  localparam int EN_HI    = 11;
  localparam int EN_LO    = 7;
  localparam int CAUSE_W  = CAUSE_HI - CAUSE_LO + 1;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_RI   = 3'd1,
    EXC_VDIS = 3'd2,
    EXC_CPU  = 3'd3,
    EXC_FPE  = 3'd4
  } exc_e;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } part_sel_t;

  // slot 0..3 -> destination index 3, 4, 6, 7
  function automatic logic [IDX_W-1:0] part_index(input int s);
    return (s < 2) ? IDX_W'(3 + s) : IDX_W'(4 + s);
  endfunction

  function automatic part_sel_t part_lookup(input logic [IDX_W-1:0] cd);
    part_sel_t r;
    r = '0;
    for (int s = 0; s < PART_N; s++) begin
      if (cd == part_index(s)) begin
        r.hit  = 1'b1;
        r.slot = SLOT_W'(s);
      end
    end
    return r;
  endfunction

  // top cause bit has no enable of its own: treat it as enabled
  function automatic logic fpe_hit(input logic [WORD_W-1:0] v);
    logic [CAUSE_W-1:0] mask;
    mask = {1'b1, v[EN_HI:EN_LO]};
    return |(v[CAUSE_HI:CAUSE_LO] & mask);
  endfunction
endpackage

// File: rtl/vcr_decode.sv
module vcr_decode
  import vcr_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output logic              legal,
  output logic              ri,
  output logic [IDX_W-1:0]  cd,
  output logic [IDX_W-1:0]  rs
);
  logic major_ok;
  logic body_ok;

  always_comb begin
    major_ok = (instr[MAJ_LO +: MAJ_W] == MAJ_CODE);
    body_ok  = (instr[FN_LO +: FN_W] == FN_CODE) &&
               (instr[MIN_LO +: MIN_W] == MIN_CODE);
    legal    = major_ok & body_ok;
    ri       = major_ok & ~body_ok;
    cd       = instr[CD_LO +: IDX_W];
    rs       = instr[RS_LO +: IDX_W];
  end
endmodule

// File: rtl/vcr_regbank.sv
module vcr_regbank #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         csr_we,
  input  logic [N-1:0] part_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] csr_q,
  output logic [W-1:0] part_q [N]
);
  always_ff @(posedge clk) begin
    if (rst)         csr_q <= '0;
    else if (csr_we) csr_q <= wdata;
  end

  for (genvar g = 0; g < N; g++) begin : g_part
    always_ff @(posedge clk) begin
      if (rst)             part_q[g] <= '0;
      else if (part_we[g]) part_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/vcr_exc.sv
module vcr_exc
  import vcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  exc_e              exc_nxt,
  input  logic [WORD_W-1:0] pc_in,
  output logic              exc_ri,
  output logic              exc_vdis,
  output logic              exc_cpu,
  output logic              exc_fpe,
  output logic [WORD_W-1:0] exc_pc
);
  exc_e exc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_q  <= EXC_NONE;
      exc_pc <= '0;
    end else begin
      exc_q <= exc_nxt;
      if (exc_nxt != EXC_NONE) exc_pc <= pc_in;
    end
  end

  always_comb begin
    exc_ri   = (exc_q == EXC_RI);
    exc_vdis = (exc_q == EXC_VDIS);
    exc_cpu  = (exc_q == EXC_CPU);
    exc_fpe  = (exc_q == EXC_FPE);
  end
endmodule

// File: rtl/vcr_write_unit.sv
module vcr_write_unit
  import vcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr_word,
  input  logic [WORD_W-1:0] src_value,
  input  logic [WORD_W-1:0] instr_pc,
  input  logic              cp0_en,
  input  logic              vec_en,
  input  logic              part_cap,
  output logic [IDX_W-1:0]  src_idx,
  output logic [WORD_W-1:0] csr_q,
  output logic [WORD_W-1:0] save_q,
  output logic [WORD_W-1:0] modify_q,
  output logic [WORD_W-1:0] map_q,
  output logic [WORD_W-1:0] unmap_q,
  output logic              exc_ri,
  output logic              exc_vdis,
  output logic              exc_cpu,
  output logic              exc_fpe,
  output logic [WORD_W-1:0] exc_pc
);
  logic             legal;
  logic             ri;
  logic [IDX_W-1:0] cd;
  part_sel_t        psel;
  logic             go;
  logic             csr_we;
  logic             part_go;
  logic [PART_N-1:0] part_we;
  logic [WORD_W-1:0] part_q [PART_N];
  logic             ri_n, vd_n, cu_n, fp_n;
  exc_e             exc_nxt;

  vcr_decode u_dec (
    .instr (instr_word),
    .legal (legal),
    .ri    (ri),
    .cd    (cd),
    .rs    (src_idx)
  );

  always_comb begin
    psel    = part_lookup(cd);
    go      = instr_valid & legal & vec_en;
    csr_we  = go & (cd == CSR_IDX);
    part_go = go & psel.hit & part_cap;
  end

  for (genvar g = 0; g < PART_N; g++) begin : g_we
    assign part_we[g] = part_go & cp0_en & (psel.slot == SLOT_W'(g));
  end

  always_comb begin
    ri_n = instr_valid & ri;
    vd_n = instr_valid & legal & ~vec_en;
    cu_n = part_go & ~cp0_en;
    fp_n = csr_we & fpe_hit(src_value);
    if (ri_n)      exc_nxt = EXC_RI;
    else if (vd_n) exc_nxt = EXC_VDIS;
    else if (cu_n) exc_nxt = EXC_CPU;
    else if (fp_n) exc_nxt = EXC_FPE;
    else           exc_nxt = EXC_NONE;
  end

  vcr_regbank #(.W(WORD_W), .N(PART_N)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .csr_we  (csr_we),
    .part_we (part_we),
    .wdata   (src_value),
    .csr_q   (csr_q),
    .part_q  (part_q)
  );

  assign save_q   = part_q[0];
  assign modify_q = part_q[1];
  assign map_q    = part_q[2];
  assign unmap_q  = part_q[3];

  vcr_exc u_exc (
    .clk      (clk),
    .rst      (rst),
    .exc_nxt  (exc_nxt),
    .pc_in    (instr_pc),
    .exc_ri   (exc_ri),
    .exc_vdis (exc_vdis),
    .exc_cpu  (exc_cpu),
    .exc_fpe  (exc_fpe),
    .exc_pc   (exc_pc)
  );
endmodule

// File: rtl/vcr_write_unit_chk.sv
module vcr_write_unit_chk
  import vcr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic [WORD_W-1:0] csr_q,
  input logic [WORD_W-1:0] save_q,
  input logic [WORD_W-1:0] modify_q,
  input logic [WORD_W-1:0] map_q,
  input logic [WORD_W-1:0] unmap_q,
  input logic              exc_ri,
  input logic              exc_vdis,
  input logic              exc_cpu,
  input logic              exc_fpe
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R10
  one_exc_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exc_ri, exc_vdis, exc_cpu, exc_fpe}));

  // R10
  exc_after_strobe_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (exc_ri | exc_vdis | exc_cpu | exc_fpe) |-> $past(instr_valid));

  // R11
  csr_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(csr_q) |-> $past(instr_valid));

  // R6
  fpe_state_chk: assert property (@(posedge clk) disable iff (rst)
    exc_fpe |-> |(csr_q[CAUSE_HI:CAUSE_LO] & {1'b1, csr_q[EN_HI:EN_LO]}));

  // R8
  cpu_nowrite_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    exc_cpu |-> $stable({save_q, modify_q, map_q, unmap_q}));

  // R4
  vdis_nowrite_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    exc_vdis |-> $stable({csr_q, save_q, modify_q, map_q, unmap_q}));

  // R3
  ri_nowrite_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    exc_ri |-> $stable({csr_q, save_q, modify_q, map_q, unmap_q}));
endmodule

bind vcr_write_unit vcr_write_unit_chk u_chk (.*);

// File: tb/sim_vcr_write_unit.sv
module sim_vcr_write_unit;
  import vcr_pkg::*;

  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [31:0] src_value = '0;
  logic [31:0] instr_pc = '0;
  logic        cp0_en = 1'b0;
  logic        vec_en = 1'b0;
  logic        part_cap = 1'b0;
  logic [4:0]  src_idx;
  logic [31:0] csr_q, save_q, modify_q, map_q, unmap_q, exc_pc;
  logic        exc_ri, exc_vdis, exc_cpu, exc_fpe;

  int total = 0;
  int bad = 0;

  always #(CLK_T/2) clk = ~clk;

  vcr_write_unit u0 (.*);

  function automatic logic [31:0] mk(input logic [4:0] cd, input logic [4:0] rs);
    return {6'b011110, 10'b0000111110, rs, cd, 6'b011001};
  endfunction

  typedef struct packed {
    logic [31:0] word;
    logic [31:0] src;
    logic        cp0;
    logic        ven;
    logic        cap;
    logic [2:0]  xexc;  // 0 none 1 ri 2 vdis 3 cpu 4 fpe
    logic [2:0]  xwr;   // 0 none 1 csr 2..5 save/modify/map/unmap
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{mk(5'd1, 5'd2), 32'h0000_0F80, 1'b1, 1'b1, 1'b1, 3'd0, 3'd1},
    '{mk(5'd1, 5'd3), 32'h0002_0000, 1'b1, 1'b1, 1'b1, 3'd4, 3'd1},
    '{mk(5'd1, 5'd3), 32'h0000_1080, 1'b1, 1'b1, 1'b1, 3'd4, 3'd1},
    '{mk(5'd1, 5'd3), 32'h0000_2080, 1'b1, 1'b1, 1'b1, 3'd0, 3'd1},
    '{mk(5'd3, 5'd1), 32'h1111_1111, 1'b1, 1'b1, 1'b1, 3'd0, 3'd2},
    '{mk(5'd4, 5'd1), 32'h2222_2222, 1'b1, 1'b1, 1'b1, 3'd0, 3'd3},
    '{mk(5'd6, 5'd1), 32'h3333_3333, 1'b1, 1'b1, 1'b1, 3'd0, 3'd4},
    '{mk(5'd7, 5'd1), 32'h4444_4444, 1'b1, 1'b1, 1'b1, 3'd0, 3'd5},
    '{mk(5'd3, 5'd1), 32'hDEAD_0001, 1'b0, 1'b1, 1'b1, 3'd3, 3'd0},
    '{mk(5'd6, 5'd1), 32'hBEEF_0002, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0},
    '{mk(5'd7, 5'd1), 32'hBEEF_0003, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0},
    '{mk(5'd2, 5'd1), 32'h5555_5555, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0},
    '{mk(5'd5, 5'd1), 32'h6666_6666, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0},
    '{mk(5'd1, 5'd1), 32'h1000_0000, 1'b1, 1'b0, 1'b1, 3'd2, 3'd0},
    '{{6'b011110, 10'h3FF, 5'd1, 5'd1, 6'b011001}, 32'h7777_0000, 1'b1, 1'b1, 1'b1, 3'd1, 3'd0},
    '{{6'b011111, 10'b0000111110, 5'd1, 5'd1, 6'b011001}, 32'h8888_0000, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0},
    '{{6'b011110, 10'b0000111110, 5'd1, 5'd1, 6'b011000}, 32'h9999_0000, 1'b1, 1'b1, 1'b1, 3'd1, 3'd0},
    '{mk(5'd1, 5'd1), 32'h0002_1000, 1'b0, 1'b0, 1'b1, 3'd2, 3'd0}
  };

  logic [31:0] m_csr;
  logic [31:0] m_part [4];
  logic [31:0] m_pc;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] got_exc();
    case ({exc_ri, exc_vdis, exc_cpu, exc_fpe})
      4'b0000: return 3'd0;
      4'b1000: return 3'd1;
      4'b0100: return 3'd2;
      4'b0010: return 3'd3;
      4'b0001: return 3'd4;
      default: return 3'd7;
    endcase
  endfunction

  function automatic string tag_of(input vec_t v);
    if (v.word[31:26] != 6'b011110) return "R2";
    case (v.xexc)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R8";
      3'd4: return "R6";
      default: ;
    endcase
    if (v.xwr == 3'd1) return "R5";
    if (v.xwr != 3'd0) return "R7";
    return "R9";
  endfunction

  task automatic strobe(input logic [31:0] w, input logic [31:0] s, input logic [31:0] pc,
                        input logic c0, input logic ve, input logic ca);
    @(negedge clk);
    instr_word = w; src_value = s; instr_pc = pc;
    cp0_en = c0; vec_en = ve; part_cap = ca;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic chk_regs(input string req);
    chk(csr_q == m_csr, req, "csr", csr_q, m_csr);
    chk({save_q, modify_q, map_q, unmap_q} == {m_part[0], m_part[1], m_part[2], m_part[3]},
        req, "partition regs", save_q ^ m_part[0] ^ modify_q ^ m_part[1], 32'h0);
  endtask

  initial begin
    #(CLK_T * 100000);
    chk(1'b0, "WD", "watchdog expired", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_csr = '0; m_pc = '0;
    for (int k = 0; k < 4; k++) m_part[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_regs("R1");
    chk(got_exc() == 3'd0, "R1", "exc after reset", 32'(got_exc()), 32'h0);
    chk(exc_pc == 32'h0, "R1", "exc_pc after reset", exc_pc, 32'h0);

    // R2 source index decode
    instr_word = mk(5'd1, 5'd19);
    #1;
    chk(src_idx == 5'd19, "R2", "src_idx", 32'(src_idx), 32'd19);

    // R11 legal word without strobe
    @(negedge clk);
    instr_word = mk(5'd1, 5'd2); src_value = 32'hFFFF_FFFF;
    cp0_en = 1'b1; vec_en = 1'b1; part_cap = 1'b1; instr_valid = 1'b0;
    @(negedge clk);
    chk(got_exc() == 3'd0, "R11", "exc without strobe", 32'(got_exc()), 32'h0);
    chk_regs("R11");

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [31:0] pc;
      pc = 32'h0000_0400 + 32'(i * 4);
      strobe(VT[i].word, VT[i].src, pc, VT[i].cp0, VT[i].ven, VT[i].cap);
      if (VT[i].xwr == 3'd1) m_csr = VT[i].src;
      else if (VT[i].xwr != 3'd0) m_part[VT[i].xwr - 3'd2] = VT[i].src;
      if (VT[i].xexc != 3'd0) m_pc = pc;
      chk(got_exc() == VT[i].xexc, tag_of(VT[i]), "exception", 32'(got_exc()), 32'(VT[i].xexc));
      chk_regs(tag_of(VT[i]));
      chk(exc_pc == m_pc, (VT[i].xexc == 3'd4) ? "R6" : "R10", "exc_pc", exc_pc, m_pc);
    end

    // R10 pulse lasts one cycle
    strobe(mk(5'd1, 5'd4), 32'h0002_0000, 32'h0000_0900, 1'b1, 1'b1, 1'b1);
    m_csr = 32'h0002_0000;
    chk(exc_fpe == 1'b1, "R6", "fpe raised", 32'(exc_fpe), 32'h1);
    chk(exc_pc == 32'h0000_0900, "R6", "fpe pc", exc_pc, 32'h0000_0900);
    @(negedge clk);
    chk(got_exc() == 3'd0, "R10", "pulse cleared", 32'(got_exc()), 32'h0);
    chk(csr_q == m_csr, "R6", "csr keeps value", csr_q, m_csr);

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_csr = '0;
    for (int k = 0; k < 4; k++) m_part[k] = '0;
    chk_regs("R1");
    chk(exc_pc == 32'h0, "R1", "exc_pc cleared", exc_pc, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule